// File: doc/BRIEF.md
# Host DMA Request Generator

This block produces the DMA request line that a memory-like slave device presents to its host. It watches two internal buffer status flags: read data waiting to be fetched, and free space for write data. Either flag being true is the ready condition. A small register file, written over a simple register-bus write port, sets how the line behaves. It holds an enable, a polarity select and a choice between a level request and a one-cycle pulse. A separate negation register lets the host drop the request regardless of buffer state.

The request logic is a five-state machine. IDLE: no request. ASSERT: a level request is held. PULSE: a single-cycle edge-mode request. HOLD: an edge-mode pulse has been given and the block waits for the ready condition to fall. BLOCKED: the host has negated the request and the block waits for the ready condition to fall.

The transitions are named as follows. IDLE goes to ASSERT (level mode, ready) or to PULSE (edge mode, ready now but not in the previous cycle). ASSERT goes to IDLE when not ready. PULSE goes to HOLD (still ready) or to IDLE. HOLD goes to IDLE when not ready. BLOCKED goes to IDLE when not ready. Three events override all of these, in falling priority: disable sends every state to IDLE, a negation write sends every state to BLOCKED, and a change of mode sends every state to IDLE.

Top module: `dmarq_gen`

## Requirements
- R1: After reset the block is disabled, the polarity is active low, level mode is selected and `dma_req_o` is 1 (inactive).
- R2: While the enable bit is 0, `dma_req_o` stays at its inactive level whatever `rd_ready_i` and `wr_space_i` do. A write that clears enable makes the request inactive from the second clock edge after the write strobe.
- R3: Polarity bit 1 means active low and bit 0 means active high. A new polarity is seen on `dma_req_o` right after the edge that samples the write.
- R4: In level mode (edge bit 0), the request is active in the cycle after an edge that samples the ready condition (`rd_ready_i | wr_space_i`) true. It goes inactive in the cycle after an edge that samples it false.
- R5: In edge mode (edge bit 1), each rising transition of the ready condition, judged between consecutive edges, gives exactly one cycle of active request. Holding the condition true gives no more pulses.
- R6: A write to the negation register, with any data, makes the request inactive from the second edge after the strobe. It then stays inactive until the ready condition has been sampled false and then true again.
- R7: The control register is at address 0: bit 0 is enable, bit 1 is polarity, bit 2 is the edge select. The negation register is at address 1. Enable and mode settings govern the request logic from the second edge after the write strobe.
- R8: A write that changes the edge select sends the machine to IDLE. This clears any pending pulse: a rising ready condition sampled at that same edge produces no pulse. A level request is rebuilt one cycle later.
- R9: Writes to any other address change nothing on `dma_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register write address |
| reg_data_i | input | 16 | Register write data |
| rd_ready_i | input | 1 | Read data available in the buffer |
| wr_space_i | input | 1 | Buffer can accept write data |
| dma_req_o | output | 1 | DMA request line to the host, polarity programmable |

## Verification
The bench goes after the one-edge gap between a register write and its effect on the request logic. A design that applied enable or mode a cycle early would drop or raise the line one cycle off from the queued expectations. It holds the ready condition high across a negation write to show that the line stays low until the condition falls. A design that merely waited one cycle would re-assert at once. It switches into edge mode while the ready condition rises, where a design that kept a pending pulse would emit a stray pulse. It also toggles polarity while disabled and makes writes to an unmapped address, where a wrong decode would disturb the line.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_PULSE,
        ST_HOLD,
        ST_BLOCKED
    } req_state_e;

    typedef struct packed {
        logic edge_mode;
        logic pol_low;
        logic en;
    } req_ctrl_t;

endpackage

// File: rtl/dmarq_regs.sv
module dmarq_regs
    import dmarq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int CTRL_ADDR = 0,
    parameter int NEG_ADDR  = 1,
    parameter int EN_BIT    = 0,
    parameter int POL_BIT   = 1,
    parameter int EDGE_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output req_ctrl_t         ctrl_o,
    output logic              neg_o,
    output logic              mode_chg_o
);

    localparam logic [ADDR_W-1:0] CtrlSel = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] NegSel  = ADDR_W'(NEG_ADDR);

    logic ctrl_hit;
    logic neg_hit;
    logic unused_data;

    assign ctrl_hit    = wr_i && (addr_i == CtrlSel);
    assign neg_hit     = wr_i && (addr_i == NegSel);
    assign unused_data = ^data_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o     <= '{edge_mode: 1'b0, pol_low: 1'b1, en: 1'b0};
            neg_o      <= 1'b0;
            mode_chg_o <= 1'b0;
        end else begin
            neg_o      <= neg_hit;
            mode_chg_o <= 1'b0;
            if (ctrl_hit) begin
                ctrl_o.en        <= data_i[EN_BIT];
                ctrl_o.pol_low   <= data_i[POL_BIT];
                ctrl_o.edge_mode <= data_i[EDGE_BIT];
                mode_chg_o       <= (data_i[EDGE_BIT] != ctrl_o.edge_mode);
            end
        end
    end

endmodule

// File: rtl/dmarq_fsm.sv
module dmarq_fsm
    import dmarq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  req_ctrl_t ctrl_i,
    input  logic      neg_i,
    input  logic      mode_chg_i,
    input  logic      rd_ready_i,
    input  logic      wr_space_i,
    output logic      active_o
);

    req_state_e state_q, state_d;
    logic       cond;
    logic       cond_q;

    assign cond = rd_ready_i | wr_space_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cond_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cond_q  <= cond;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!ctrl_i.en) begin
            state_d = ST_IDLE;
        end else if (neg_i) begin
            state_d = ST_BLOCKED;
        end else if (mode_chg_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!ctrl_i.edge_mode && cond)
                        state_d = ST_ASSERT;
                    else if (ctrl_i.edge_mode && cond && !cond_q)
                        state_d = ST_PULSE;
                end
                ST_ASSERT:  if (!cond) state_d = ST_IDLE;
                ST_PULSE:   state_d = cond ? ST_HOLD : ST_IDLE;
                ST_HOLD:    if (!cond) state_d = ST_IDLE;
                ST_BLOCKED: if (!cond) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ASSERT, ST_PULSE: active_o = 1'b1;
            default:             active_o = 1'b0;
        endcase
    end

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i.en |=> !active_o);

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i.edge_mode && active_o) |=> !active_o);

    // R6
    negation_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg_i |=> !active_o);

    // R4
    rise_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> $past(cond));

endmodule

// File: rtl/dmarq_pin.sv
module dmarq_pin (
    input  logic active_i,
    input  logic pol_low_i,
    output logic pin_o
);

    assign pin_o = pol_low_i ? ~active_i : active_i;

endmodule

// File: rtl/dmarq_gen.sv
module dmarq_gen
    import dmarq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_data_i,
    input  logic              rd_ready_i,
    input  logic              wr_space_i,
    output logic              dma_req_o
);

    req_ctrl_t ctrl;
    logic      neg;
    logic      mode_chg;
    logic      active;

    dmarq_regs #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .data_i    (reg_data_i),
        .ctrl_o    (ctrl),
        .neg_o     (neg),
        .mode_chg_o(mode_chg)
    );

    dmarq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_i    (ctrl),
        .neg_i     (neg),
        .mode_chg_i(mode_chg),
        .rd_ready_i(rd_ready_i),
        .wr_space_i(wr_space_i),
        .active_o  (active)
    );

    dmarq_pin u_pin (
        .active_i (active),
        .pol_low_i(ctrl.pol_low),
        .pin_o    (dma_req_o)
    );

    // R3
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (dma_req_o == ctrl.pol_low));

endmodule

// File: tb/sim_dmarq_gen.sv
`timescale 1ns/1ps
module sim_dmarq_gen;

    localparam logic [3:0] CTRL = 4'h0;
    localparam logic [3:0] NEG  = 4'h1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] data = '0;
    logic        rd = 1'b0;
    logic        ws = 1'b0;
    logic        req;

    int checks = 0;
    int errors = 0;
    logic pol_m = 1'b1;
    logic exp_q[$];
    string tag_q[$];
    logic mon_e;
    string mon_t;

    always #2.5 clk = ~clk;

    dmarq_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_data_i(data), .rd_ready_i(rd), .wr_space_i(ws), .dma_req_o(req)
    );

    // driver: one cycle of stimulus, expected pin level after the next edge
    task automatic cyc(input logic r, input logic w, input logic we,
                       input logic [3:0] a, input logic [15:0] d,
                       input logic act, input string tag);
        @(negedge clk);
        rd = r; ws = w; wr = we; addr = a; data = d;
        if (we && a == CTRL) pol_m = d[1];
        exp_q.push_back(pol_m ? ~act : act);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic r, input logic w, input logic act, input string tag);
        cyc(r, w, 1'b0, 4'h0, 16'h0, act, tag);
    endtask

    // monitor: compare against the scoreboard after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            checks++;
            if (req !== mon_e) begin
                errors++;
                $display("FAIL %s: dma_req_o=%b expected %b at %0t", mon_t, req, mon_e, $time);
            end
        end
    end

    initial begin
        #25000;
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req !== 1'b1) begin
            errors++;
            $display("FAIL R1: dma_req_o=%b expected 1", req);
        end
        // R2 disabled: ready ignored
        idle(1, 0, 0, "R2"); idle(1, 0, 0, "R2"); idle(0, 1, 0, "R2"); idle(1, 1, 0, "R2");
        // R7 enable, level mode, active low
        cyc(1, 0, 1, CTRL, 16'h0003, 0, "R7");
        idle(1, 0, 1, "R4"); idle(1, 0, 1, "R4"); idle(1, 0, 1, "R4");
        idle(0, 0, 0, "R4"); idle(0, 1, 1, "R4");
        // R6 negation during active level request
        cyc(0, 1, 1, NEG, 16'h1234, 1, "R6");
        idle(1, 0, 0, "R6"); idle(1, 0, 0, "R6"); idle(1, 1, 0, "R6");
        idle(0, 0, 0, "R6"); idle(1, 0, 1, "R6");
        // R9 unmapped write
        cyc(1, 0, 1, 4'h7, 16'hFFFF, 1, "R9");
        idle(1, 0, 1, "R9"); idle(1, 0, 1, "R9");
        // R8 switch to edge mode while ready rises
        idle(0, 0, 0, "R4");
        cyc(0, 0, 1, CTRL, 16'h0007, 0, "R8");
        idle(1, 0, 0, "R8");
        idle(1, 0, 0, "R5"); idle(0, 0, 0, "R5");
        idle(1, 0, 1, "R5"); idle(1, 0, 0, "R5"); idle(0, 0, 0, "R5");
        idle(0, 1, 1, "R5"); idle(0, 0, 0, "R5");
        // R6 negation in edge mode
        cyc(0, 0, 1, NEG, 16'h0000, 0, "R6");
        idle(1, 0, 0, "R6"); idle(0, 0, 0, "R6"); idle(1, 0, 1, "R6");
        // R3 active high, edge mode
        cyc(0, 0, 1, CTRL, 16'h0005, 0, "R3");
        idle(0, 1, 1, "R3"); idle(0, 1, 0, "R3");
        // R8 back to level, active high
        cyc(1, 0, 1, CTRL, 16'h0001, 0, "R8");
        idle(1, 0, 0, "R8");
        idle(1, 0, 1, "R3"); idle(1, 0, 1, "R4");
        // R2 disable while asserted
        cyc(1, 0, 1, CTRL, 16'h0000, 1, "R2");
        idle(1, 0, 0, "R2"); idle(1, 0, 0, "R2"); idle(0, 1, 0, "R2");
        // R3 polarity change while disabled
        cyc(1, 0, 1, CTRL, 16'h0002, 0, "R3");
        idle(1, 1, 0, "R3");
        idle(0, 0, 0, "R3");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule